// File: doc/BRIEF.md
# Level-Interrupt GPIO Controller

A register-mapped controller for a bank of general-purpose pins, with twelve pins by default. Software uses a simple 32-bit word bus to set output values and per-pin drive enables, and to read back the pin levels after they pass through a synchronizer. A mux-selection word is held in a register and driven straight out of the block so that neighbouring pad logic can use it. The block does not use that word itself.

Each pin can raise a level-sensitive interrupt, and a polarity bit chooses whether the high or the low level is the active one. A pin's status bit is set whenever its synchronized level is active, whether or not the pin is enabled in the mask. Software acknowledges a status bit by writing a one to it. If the source is still active, the bit is set again one cycle after it clears. The single interrupt output is the OR of every status bit that is also enabled in the mask.

Top module: `gpio_lvl_ctrl`

## Requirements
- R1: Word 0x00 (output value) drives `pin_out` and word 0x04 (drive enable) drives `pin_oe`. Bit n belongs to pin n, both words read back what was written, and bits at or above NPINS read as zero.
- R2: Word 0x08 returns the pin levels after two flip-flop stages. A pin change made in a cycle is visible on the read port after the second rising edge that follows it. Writes to 0x08 change nothing.
- R3: The polarity bit of pin n is bit 4*(n mod 8) of word 0x10 for pins 0 to 7, and of word 0x18 for pins 8 and up. A value of 0 makes the high level active and a value of 1 makes the low level active. All other bits of these two words read as zero.
- R4: Status bit n in word 0x0C is set on the clock edge after the synchronized level of pin n becomes active. This happens regardless of the mask, and the bit stays set after the level goes inactive.
- R5: Writing a 1 to a bit of word 0x0C clears that bit. Writing a 0 to a bit leaves it unchanged.
- R6: A cleared status bit reads 0 in the cycle after the acknowledge write. If the pin's level is still active, the bit reads 1 again one cycle later.
- R7: `irq` is high exactly when some bit is set both in status and in the mask word 0x14, where a 1 enables the pin.
- R8: Word 0x1C keeps all 32 written bits, reads them back, and drives them on `mux_out`.
- R9: After reset the output, drive-enable, mask, polarity, status and mux words are all zero, `irq` is low and `pin_oe` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Bus access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 5 | Byte address; bits 4:2 select the word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output value for each pin |
| pin_oe | output | 12 | Drive enable for each pin |
| mux_out | output | 32 | Stored mux-selection word |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bench builds the block with its default parameters: twelve pins, two synchronizer stages and a 32-bit bus. With twelve pins, the second polarity word is only partly populated, so the bench can check that bits which decode to no pin read as zero. The directed sequences sample the input word and the status word on each cycle around a pin change and around an acknowledge. These samples pin down the two-stage synchronizer latency and the one-cycle clear-then-set pattern. The random rounds mix polarities, masks and pin levels, and compare status and `irq` against a model of the active levels.

// File: rtl/gpio_lvl_pkg.sv
package gpio_lvl_pkg;
   // word index taken from byte address bits [4:2]
   typedef enum logic [2:0] {
      WI_OUT     = 3'd0,
      WI_OE      = 3'd1,
      WI_IN      = 3'd2,
      WI_STAT    = 3'd3,
      WI_POL_LO  = 3'd4,
      WI_MASK    = 3'd5,
      WI_POL_HI  = 3'd6,
      WI_MUX     = 3'd7
   } word_idx_t;

   localparam int unsigned POL_PER_WORD = 8;
   localparam int unsigned POL_STRIDE   = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 12,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_lvl_detect.sv
module gpio_lvl_detect #(
   parameter int unsigned NPINS = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] pol,
   input  logic [NPINS-1:0] ack,
   output logic [NPINS-1:0] status
);
   logic [NPINS-1:0] active;

   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      // pol = 0: high active, pol = 1: low active
      assign active[n] = lvl[n] ^ pol[n];

      // acknowledge wins for one cycle, then an active level sets it again
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      status[n] <= 1'b0;
         else if (ack[n]) status[n] <= 1'b0;
         else if (active[n]) status[n] <= 1'b1;
      end
   end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned NPINS  = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned MUX_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NPINS-1:0]  in_sync,
   input  logic [NPINS-1:0]  status,
   output logic [NPINS-1:0]  out_q,
   output logic [NPINS-1:0]  oe_q,
   output logic [NPINS-1:0]  mask_q,
   output logic [NPINS-1:0]  pol_q,
   output logic [NPINS-1:0]  ack,
   output logic [MUX_W-1:0]  mux_q
);
   localparam int unsigned LO_PINS = (NPINS < POL_PER_WORD) ? NPINS : POL_PER_WORD;

   word_idx_t widx;
   logic      wr;
   logic [DATA_W-1:0] pol_lo_rd, pol_hi_rd;

   assign widx = word_idx_t'(reg_addr[4:2]);
   assign wr   = reg_en && reg_we;
   assign ack  = (wr && widx == WI_STAT) ? reg_wdata[NPINS-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         oe_q   <= '0;
         mask_q <= '0;
         mux_q  <= '0;
      end else if (wr) begin
         case (widx)
            WI_OUT:  out_q  <= reg_wdata[NPINS-1:0];
            WI_OE:   oe_q   <= reg_wdata[NPINS-1:0];
            WI_MASK: mask_q <= reg_wdata[NPINS-1:0];
            WI_MUX:  mux_q  <= reg_wdata[MUX_W-1:0];
            default: ;
         endcase
      end
   end

   // polarity bits sit on nibble boundaries across two words
   for (genvar n = 0; n < NPINS; n++) begin : g_pol
      localparam word_idx_t PW  = (n < POL_PER_WORD) ? WI_POL_LO : WI_POL_HI;
      localparam int unsigned PB = POL_STRIDE * (n % POL_PER_WORD);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                pol_q[n] <= 1'b0;
         else if (wr && widx == PW) pol_q[n] <= reg_wdata[PB];
      end
   end

   always_comb begin
      pol_lo_rd = '0;
      pol_hi_rd = '0;
      for (int n = 0; n < LO_PINS; n++)
         pol_lo_rd[POL_STRIDE*n] = pol_q[n];
      for (int n = POL_PER_WORD; n < NPINS; n++)
         pol_hi_rd[POL_STRIDE*(n-POL_PER_WORD)] = pol_q[n];
   end

   always_comb begin
      reg_rdata = '0;
      case (widx)
         WI_OUT:    reg_rdata[NPINS-1:0] = out_q;
         WI_OE:     reg_rdata[NPINS-1:0] = oe_q;
         WI_IN:     reg_rdata[NPINS-1:0] = in_sync;
         WI_STAT:   reg_rdata[NPINS-1:0] = status;
         WI_POL_LO: reg_rdata = pol_lo_rd;
         WI_MASK:   reg_rdata[NPINS-1:0] = mask_q;
         WI_POL_HI: reg_rdata = pol_hi_rd;
         WI_MUX:    reg_rdata[MUX_W-1:0] = mux_q;
         default:   reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_lvl_ctrl.sv
module gpio_lvl_ctrl
   import gpio_lvl_pkg::*;
#(
   parameter int unsigned NPINS       = 12,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MUX_W       = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_en,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NPINS-1:0]  pin_in,
   output logic [NPINS-1:0]  pin_out,
   output logic [NPINS-1:0]  pin_oe,
   output logic [MUX_W-1:0]  mux_out,
   output logic              irq
);
   if (NPINS < 1 || NPINS > 2*POL_PER_WORD) begin : g_bad_npins
      $error("gpio_lvl_ctrl: NPINS must be 1..16");
   end
   if (DATA_W != 32 || NPINS >= DATA_W) begin : g_bad_dw
      $error("gpio_lvl_ctrl: DATA_W must be 32 and exceed NPINS");
   end
   if (ADDR_W < 5) begin : g_bad_aw
      $error("gpio_lvl_ctrl: ADDR_W must be at least 5");
   end
   if (MUX_W < 1 || MUX_W > DATA_W) begin : g_bad_mux
      $error("gpio_lvl_ctrl: MUX_W must be 1..DATA_W");
   end

   logic [NPINS-1:0] in_sync, stat_q, mask_q, pol_q, ack;

   gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_async(pin_in), .q_sync(in_sync)
   );

   gpio_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MUX_W(MUX_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .in_sync(in_sync), .status(stat_q),
      .out_q(pin_out), .oe_q(pin_oe), .mask_q(mask_q), .pol_q(pol_q),
      .ack(ack), .mux_q(mux_out)
   );

   gpio_lvl_detect #(.NPINS(NPINS)) u_det (
      .clk(clk), .rst_n(rst_n), .lvl(in_sync), .pol(pol_q),
      .ack(ack), .status(stat_q)
   );

   assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/gpio_lvl_chk.sv
module gpio_lvl_chk #(
   parameter int unsigned NPINS  = 12,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_en,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [NPINS-1:0]  lvl,
   input logic [NPINS-1:0]  pol,
   input logic [NPINS-1:0]  status,
   input logic [NPINS-1:0]  pin_oe,
   input logic              irq
);
   logic [NPINS-1:0] chk_ack, chk_act;
   logic             rd_narrow;

   assign chk_ack = (reg_en && reg_we && reg_addr[4:2] == 3'd3) ? reg_wdata[NPINS-1:0] : '0;
   assign chk_act = lvl ^ pol;
   assign rd_narrow = (reg_addr[4:2] <= 3'd3) || (reg_addr[4:2] == 3'd5);

   AST_LATCH_ON_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(chk_act) & ~$past(chk_ack) & ~status) == '0)); // R4

   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & $past(chk_ack)) == '0)); // R5

   AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status & ~$past(status) & ~$past(chk_act)) == '0)); // R6

   AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0)); // R7

   AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd_narrow |-> ((reg_rdata >> NPINS) == '0)); // R1

   AST_OE_RESET_ZERO: assert property (@(posedge clk)
      $rose(rst_n) |-> (pin_oe == '0)); // R9
endmodule

bind gpio_lvl_ctrl gpio_lvl_chk #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
   .lvl(in_sync), .pol(pol_q), .status(stat_q), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/sim_gpio_lvl_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_lvl_ctrl;
   localparam int N = 12;
   localparam logic [31:0] PMASK = 32'h0000_0FFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_en = 1'b0, reg_we = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out, pin_oe;
   logic [31:0] mux_out;
   logic        irq;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2 clk = ~clk;  // 250 MHz

   gpio_lvl_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
      .mux_out(mux_out), .irq(irq)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      @(negedge clk);
      reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_en = 1'b0; reg_we = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_now(logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   function automatic logic [N-1:0] pol_of(logic [31:0] lo, logic [31:0] hi);
      logic [N-1:0] p;
      for (int n = 0; n < N; n++)
         p[n] = (n < 8) ? lo[4*n] : hi[4*(n-8)];
      return p;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'h0C0FFEE5));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R9 reset values
      for (int a = 0; a < 8; a++) begin
         rd_now(5'(a*4), v);
         check("R9 reset word", v, 32'h0);
      end
      check("R9 pin_oe", 32'(pin_oe), 32'h0);
      check("R9 irq", 32'(irq), 32'h0);
      check("R9 mux_out", mux_out, 32'h0);

      // R1 output and enable, upper bits zero
      wr(5'h00, 32'hFFFF_FFFF);
      rd_now(5'h00, v); check("R1 out readback", v, PMASK);
      check("R1 pin_out", 32'(pin_out), PMASK);
      wr(5'h04, 32'h1234_5A5A);
      rd_now(5'h04, v); check("R1 oe readback", v, 32'h0000_0A5A);
      check("R1 pin_oe", 32'(pin_oe), 32'h0000_0A5A);

      // R8 mux word
      wr(5'h1C, 32'hDEAD_BEEF);
      rd_now(5'h1C, v); check("R8 mux readback", v, 32'hDEAD_BEEF);
      check("R8 mux_out", mux_out, 32'hDEAD_BEEF);

      // R3 polarity layout
      wr(5'h10, 32'hFFFF_FFFF);
      rd_now(5'h10, v); check("R3 pol lo layout", v, 32'h1111_1111);
      wr(5'h18, 32'hFFFF_FFFF);
      rd_now(5'h18, v); check("R3 pol hi layout", v, 32'h0000_1111);
      wr(5'h10, 32'h0); wr(5'h18, 32'h0); wr(5'h14, 32'h0);
      wr(5'h0C, PMASK);
      rd_now(5'h0C, v); check("R5 status cleared", v, 32'h0);

      // R2 / R4 latency: change at N0, visible at N2, status at N3
      @(negedge clk); pin_in = 12'h008;
      rd_now(5'h08, v); check("R2 in before edge", v, 32'h0);
      @(negedge clk);
      rd_now(5'h08, v); check("R2 in after one edge", v, 32'h0);
      @(negedge clk);
      rd_now(5'h08, v); check("R2 in after two edges", v, 32'h008);
      rd_now(5'h0C, v); check("R4 status not yet", v, 32'h0);
      @(negedge clk);
      rd_now(5'h0C, v); check("R4 status set masked", v, 32'h008);
      check("R7 irq masked", 32'(irq), 32'h0);
      wr(5'h14, 32'h008);
      check("R7 irq enabled", 32'(irq), 32'h1);

      // R6 re-latch after acknowledge while active
      wr(5'h0C, 32'h008);
      rd_now(5'h0C, v); check("R6 cleared cycle", v, 32'h0);
      check("R7 irq follows clear", 32'(irq), 32'h0);
      @(negedge clk);
      rd_now(5'h0C, v); check("R6 re-set cycle", v, 32'h008);

      // R5 write-zero keeps, write-one clears when inactive
      pin_in = 12'h000;
      repeat (4) @(negedge clk);
      rd_now(5'h0C, v); check("R4 latched after level gone", v, 32'h008);
      wr(5'h0C, 32'hFFFF_FFF7);
      repeat (2) @(negedge clk);
      rd_now(5'h0C, v); check("R5 zero keeps bit", v, 32'h008);
      wr(5'h0C, 32'h008);
      repeat (3) @(negedge clk);
      rd_now(5'h0C, v); check("R5 one clears bit", v, 32'h0);

      // R3 active-low on pin 9 (hi word bit 4)
      wr(5'h18, 32'h0000_0010);
      repeat (4) @(negedge clk);
      rd_now(5'h0C, v); check("R3 active low pin9", v, 32'h200);
      wr(5'h18, 32'h0);
      wr(5'h0C, PMASK);
      @(negedge clk);

      // R2 writes to input word ignored
      pin_in = 12'h5A3;
      repeat (3) @(negedge clk);
      wr(5'h08, 32'hFFFF_FFFF);
      rd_now(5'h08, v); check("R2 write ignored", v, 32'h5A3);

      // random rounds
      for (int it = 0; it < 40; it++) begin
         logic [31:0] lo, hi, mk, ov;
         logic [N-1:0] act;
         lo = $urandom; hi = $urandom; mk = $urandom; ov = $urandom;
         @(negedge clk);
         pin_in = N'($urandom);
         wr(5'h10, lo); wr(5'h18, hi); wr(5'h14, mk); wr(5'h00, ov);
         repeat (3) @(negedge clk);
         wr(5'h0C, PMASK);
         repeat (3) @(negedge clk);
         act = pin_in ^ pol_of(lo, hi);
         rd_now(5'h08, v); check("R2 random in", v, 32'(pin_in));
         rd_now(5'h0C, v); check("R4 random status", v, 32'(act));
         check("R7 random irq", 32'(irq), 32'(|(act & mk[N-1:0])));
         check("R1 random out", 32'(pin_out), ov & PMASK);
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule